// File: doc/BRIEF.md
# Limit-Match System Counter/Timer

This block is a memory-mapped up-counter. It advances by one unit on each pulse of a tick-enable input, which a chip-level prescaler drives once every 500 ns. It compares the running count with a programmable limit. When a tick brings the count equal to a non-zero limit, the block sets a match flag and raises a level interrupt. On the following tick the count returns to zero, so the timer fires periodically. A limit of zero turns the block into a free-running counter that never flags a match and never interrupts.

Software reaches the block over a 32-bit register bus. Only full-word accesses are accepted, across five word slots. The count sits in bits 30..9 of the value that is read back, and the match flag sits in bit 31. Reading the limit slot acknowledges the match. Software can change the limit in two ways: one slot restarts the count from zero, and the other keeps the count running. Read data is combinational within the access cycle. All side effects take place at the clock edge that ends the access.

Top module: `lmt_timer`

## Requirements
- R1: After reset the limit, the count, the match flag and `irq` are all zero, and the counter advances in free-run.
- R2: Each cycle with `tick` high adds one to the count. A read of byte address 0x04 returns the count in bits 30..9, zeros in bits 8..0 and the match flag in bit 31.
- R3: A tick that makes the count equal to a non-zero limit sets the match flag and `irq` at that edge. The next tick reloads the count to zero.
- R4: With a limit of zero, ticks advance the count and never set the match flag or `irq`.
- R5: A write to byte address 0x00 stores `wdata & 0x7FFFFE00` as the limit, returns the count to zero and drops `irq`. It leaves the match flag unchanged.
- R6: A write to byte address 0x08 stores `wdata & 0x7FFFFE00` as the limit. It keeps the count and leaves `irq` unchanged.
- R7: A read of byte address 0x00 returns the limit in bits 30..9 with all other bits zero. It clears the match flag and drops `irq`.
- R8: Writes to byte addresses 0x04, 0x0C and 0x10 have no effect. Reads of 0x0C, 0x10 and 0x14 return zero.
- R9: An access counts only when `be` is 4'hF and `addr[1:0]` is 0. Any other access changes nothing and reads as zero.
- R10: Once raised, `irq` stays high across further ticks and count reloads until a limit read or a limit write at 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| be | input | 4 | Byte enables; must be all ones |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| tick | input | 1 | Count enable, one pulse per time unit |
| irq | output | 1 | Level interrupt on limit match |

## Verification
The main function is driven from a table of limits and tick counts. The tick counts are chosen to land just below the limit, exactly on it, one tick past it (the reload), and several periods past it. These cases separate an off-by-one compare from a missing reload and from an interrupt that drops on its own. A zero limit and a limit of one cover the free-run and shortest-period corners. Limit values written with junk in bits 31 and 8..0 show whether masking is applied. Directed sequences then separate the restarting limit write from the non-restarting one, a limit read from a limit write (the match flag survives only the write), and valid accesses from partial or misaligned ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        SLOT_LIMIT = 3'd0,
        SLOT_COUNT = 3'd1,
        SLOT_LIMNR = 3'd2,
        SLOT_STAT  = 3'd3,
        SLOT_MODE  = 3'd4
    } slot_e;

    typedef struct packed {
        logic ld_restart;
        logic ld_keep;
        logic ack;
    } tmr_cmd_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output tmr_cmd_t          cmd,
    output logic              rd_ok,
    output logic [WORD_W-1:0] word
);

    logic ok;

    always_comb begin
        ok    = req && (be == 4'hF) && (addr[1:0] == 2'b00);
        word  = addr[ADDR_W-1:2];
        rd_ok = ok && !we;
        cmd   = '0;
        cmd.ld_restart = ok && we  && (word == WORD_W'(SLOT_LIMIT));
        cmd.ld_keep    = ok && we  && (word == WORD_W'(SLOT_LIMNR));
        cmd.ack        = ok && !we && (word == WORD_W'(SLOT_LIMIT));
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_cmd_t         cmd,
    input  logic [CNT_W-1:0] wlim,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             rch_q,
    output logic             irq_q
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] count;
        logic             reached;
        logic             irq;
    } st_t;

    st_t st_d, st_q;
    logic armed;

    always_comb begin
        st_d  = st_q;
        armed = (st_q.limit != '0);
        if (cmd.ld_restart) begin
            st_d.limit = wlim;
            st_d.count = '0;
            st_d.irq   = 1'b0;
        end else begin
            if (cmd.ld_keep) begin
                st_d.limit = wlim;
            end
            if (cmd.ack) begin
                st_d.reached = 1'b0;
                st_d.irq     = 1'b0;
            end
            if (tick) begin
                if (armed && (st_q.count == st_q.limit)) begin
                    st_d.count = '0;
                end else begin
                    st_d.count = st_q.count + CNT_W'(1);
                end
                if (armed && (st_d.count == st_q.limit)) begin
                    st_d.reached = 1'b1;
                    st_d.irq     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.count;
    assign lim_q = st_q.limit;
    assign rch_q = st_q.reached;
    assign irq_q = st_q.irq;

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 22,
    parameter int TICK_LSB = 9,
    parameter int WORD_W   = 3,
    localparam int DATA_W  = CNT_W + TICK_LSB + 1
) (
    input  logic              rd_ok,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  lim,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              rch,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (word)
                WORD_W'(SLOT_LIMIT): rdata = {1'b0, lim, {TICK_LSB{1'b0}}};
                WORD_W'(SLOT_COUNT): rdata = {rch, cnt, {TICK_LSB{1'b0}}};
                default:             rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int TICK_LSB = 9,
    localparam int CNT_W   = 31 - TICK_LSB,
    localparam int WORD_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              tick,
    output logic              irq
);

    tmr_cmd_t          cmd;
    logic              rd_ok;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim_q;
    logic              rch_q;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[31], wdata[TICK_LSB-1:0]};

    tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req   (req),
        .we    (we),
        .addr  (addr),
        .be    (be),
        .cmd   (cmd),
        .rd_ok (rd_ok),
        .word  (word)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cmd   (cmd),
        .wlim  (wdata[TICK_LSB +: CNT_W]),
        .cnt_q (cnt_q),
        .lim_q (lim_q),
        .rch_q (rch_q),
        .irq_q (irq)
    );

    tmr_rdmux #(.CNT_W(CNT_W), .TICK_LSB(TICK_LSB), .WORD_W(WORD_W)) u_rd (
        .rd_ok (rd_ok),
        .word  (word),
        .lim   (lim_q),
        .cnt   (cnt_q),
        .rch   (rch_q),
        .rdata (rdata)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int ADDR_W   = 5,
    parameter int TICK_LSB = 9,
    parameter int CNT_W    = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        be,
    input logic              tick,
    input logic              irq,
    input logic [31:0]       rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  lim_q
);

    logic              ok;
    logic [ADDR_W-3:0] w;

    assign ok = req && (be == 4'hF) && (addr[1:0] == 2'b00);
    assign w  = addr[ADDR_W-1:2];

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (rdata[TICK_LSB-1:0] == '0));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (lim_q != '0) && (cnt_q == lim_q) && !(ok && we && (w == '0)))
        |=> (cnt_q == '0));

    a_r4_free_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(lim_q) != '0));

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && we && (w == '0)) |=> ((cnt_q == '0) && !irq));

    a_r6_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && we && (w == 2) && !tick) |=> $stable(cnt_q));

    a_r7_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !we && (w == '0) && !tick) |=> !irq);

    a_r8_count_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && we && (w == 1) && !tick) |=> ($stable(cnt_q) && $stable(lim_q)));

    a_r9_bad_access_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ok) |-> (rdata == '0));

    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ok && (w == '0))) |=> irq);

endmodule

bind lmt_timer tmr_chk #(.ADDR_W(ADDR_W), .TICK_LSB(TICK_LSB), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .we    (we),
    .addr  (addr),
    .be    (be),
    .tick  (tick),
    .irq   (irq),
    .rdata (rdata),
    .cnt_q (cnt_q),
    .lim_q (lim_q)
);

// File: tb/tb_lmt_timer.sv
module tb_lmt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lmt_timer dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .we    (we),
        .addr  (addr),
        .be    (be),
        .wdata (wdata),
        .rdata (rdata),
        .tick  (tick),
        .irq   (irq)
    );

    // limit(22) ticks(8) exp_count(22) exp_match(1) exp_irq(1)
    localparam logic [53:0] VEC [0:7] = '{
        {22'd3,  8'd2, 22'd2, 1'b0, 1'b0},
        {22'd3,  8'd3, 22'd3, 1'b1, 1'b1},
        {22'd3,  8'd4, 22'd0, 1'b1, 1'b1},
        {22'd3,  8'd7, 22'd3, 1'b1, 1'b1},
        {22'd1,  8'd1, 22'd1, 1'b1, 1'b1},
        {22'd1,  8'd2, 22'd0, 1'b1, 1'b1},
        {22'd0,  8'd5, 22'd5, 1'b0, 1'b0},
        {22'd10, 8'd9, 22'd9, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [3:0] b,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; be = b; wdata = d;
        #1 q = rdata;
        @(posedge clk);
        #1 req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] q;
        acc(1'b1, a, 4'hF, d, q);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] q);
        acc(1'b0, a, 4'hF, 32'h0, q);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    endtask

    function automatic logic [31:0] cw(input logic m, input logic [21:0] c);
        return {m, c, 9'h0};
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        rd(5'h04, q); chk("R1 count after reset", q, 32'h0);
        rd(5'h00, q); chk("R1 limit after reset", q, 32'h0);

        // main table
        for (int i = 0; i < 8; i++) begin
            logic [21:0] lim, ec;
            logic [7:0]  nt;
            logic        em, ei;
            lim = VEC[i][53:32]; nt = VEC[i][31:24]; ec = VEC[i][23:2];
            em = VEC[i][1]; ei = VEC[i][0];
            wr(5'h00, {1'b1, lim, 9'h1FF});
            rd(5'h00, q); chk("R5 R7 masked limit readback", q, cw(1'b0, lim));
            chk("R7 irq low after ack", {31'h0, irq}, 32'h0);
            ticks(int'(nt));
            rd(5'h04, q); chk("R2 R3 R4 count and match flag", q, cw(em, ec));
            chk("R3 R4 R10 irq level", {31'h0, irq}, {31'h0, ei});
        end

        // R8: ignored writes, zero reads (state: limit 10, count 9)
        wr(5'h04, 32'h7FFF_FE00);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h04, q); chk("R8 count unchanged after ignored writes", q, cw(1'b0, 22'd9));
        rd(5'h00, q); chk("R8 limit unchanged after ignored writes", q, cw(1'b0, 22'd10));
        rd(5'h0C, q); chk("R8 status reads zero", q, 32'h0);
        rd(5'h10, q); chk("R8 mode reads zero", q, 32'h0);
        rd(5'h14, q); chk("R8 unmapped reads zero", q, 32'h0);

        // R9: partial and misaligned accesses
        acc(1'b1, 5'h00, 4'h3, 32'h0000_0400, q);
        rd(5'h00, q); chk("R9 partial write ignored", q, cw(1'b0, 22'd10));
        rd(5'h04, q); chk("R9 count kept after partial write", q, cw(1'b0, 22'd9));
        acc(1'b0, 5'h01, 4'hF, 32'h0, q); chk("R9 misaligned read zero", q, 32'h0);
        acc(1'b0, 5'h04, 4'h1, 32'h0, q); chk("R9 byte read zero", q, 32'h0);

        // R6: limit change without restart
        wr(5'h08, {1'b1, 22'd12, 9'h155});
        rd(5'h04, q); chk("R6 count kept", q, cw(1'b0, 22'd9));
        ticks(3);
        chk("R6 R3 match on new limit irq", {31'h0, irq}, 32'h1);

        // R9: invalid limit read does not acknowledge
        acc(1'b0, 5'h00, 4'h7, 32'h0, q);
        chk("R9 invalid ack read zero", q, 32'h0);
        chk("R9 irq kept after invalid read", {31'h0, irq}, 32'h1);

        // R7: limit read acknowledges
        rd(5'h00, q); chk("R7 limit value", q, cw(1'b0, 22'd12));
        chk("R7 irq dropped", {31'h0, irq}, 32'h0);
        rd(5'h04, q); chk("R7 match flag cleared", q, cw(1'b0, 22'd12));
        ticks(1);
        rd(5'h04, q); chk("R3 reload to zero", q, cw(1'b0, 22'd0));

        // R5: restart write drops irq, match flag kept
        ticks(12);
        chk("R10 irq after second period", {31'h0, irq}, 32'h1);
        wr(5'h00, {10'h0, 22'd12} << 9);
        chk("R5 irq dropped by write", {31'h0, irq}, 32'h0);
        rd(5'h04, q); chk("R5 count zero match flag kept", q, cw(1'b1, 22'd0));

        // R1: reset in mid-run
        ticks(5);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 irq after second reset", {31'h0, irq}, 32'h0);
        rd(5'h04, q); chk("R1 count after second reset", q, 32'h0);
        rd(5'h00, q); chk("R1 limit after second reset", q, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule